// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block is a single byte-wide output port that hands data to a peripheral under a two-wire handshake. A host writes a byte by pulling a select line and an active-low write strobe low together. When the write ends, the byte is latched onto the port pins and an active-low buffer-full line tells the peripheral that fresh data is waiting. The peripheral takes the byte and pulses its active-low acknowledge. That pulse empties the buffer. When acknowledge goes high again, the port raises an interrupt request, provided the interrupt is enabled, so the host knows it may send the next byte.

The interrupt enable is one bit. It is loaded by a single-cycle set/reset command that is synchronous to the clock. The write strobe, the select and the acknowledge come from outside the clock domain. They pass through a synchronizer before any edge is detected. A three-bit status word shows the buffer-full flag, the interrupt and the enable.

Top module: `hsk_out_port`

## Requirements
- R1: After reset, `obf_n` is high, `irq` is low, `status` is 3'b000 and `port_out` is 0.
- R2: A write is the interval during which `sel_n` and `wr_n` are both low. When it ends (either line rises), `port_out` takes `wdata`. If acknowledge is not low, `obf_n` goes low.
- R3: While `ack_n` is held low, `obf_n` is high. This holds even when a write ends during that time, and the data is still latched.
- R4: When `ack_n` rises with the buffer empty and the enable set, `irq` goes high. Setting the enable alone does not raise `irq`.
- R5: The start of a write clears `irq`.
- R6: A cycle with `ien_we` high loads `ien_val` into the enable. A cleared enable forces `irq` low.
- R7: Pulsing `wr_n` while `sel_n` is high has no effect on `port_out`, `obf_n` or `irq`.
- R8: The bits of `status` are: bit 0 is buffer full (the inverse of `obf_n`), bit 1 is `irq`, and bit 2 is the enable.
- R9: A change on `wr_n`, `sel_n` or `ack_n` shows at the outputs after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low port select, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| wdata | input | 8 | Write data, held stable around the end of a write |
| ack_n | input | 1 | Active-low acknowledge from the peripheral, asynchronous |
| ien_we | input | 1 | Single-cycle enable set/reset command, synchronous |
| ien_val | input | 1 | Value loaded into the enable |
| port_out | output | 8 | Latched output data |
| obf_n | output | 1 | Active-low buffer full |
| irq | output | 1 | Interrupt request, active high |
| status | output | 3 | {enable, irq, buffer full} |

## Verification
The assertions assume that every strobe level lasts longer than the synchronizer depth. They also assume that `wdata` stays steady from the start of a write until three clocks after it ends, because the data is taken at the synchronized end edge. The bench holds each strobe level for at least three clock cycles, and it changes `wdata` only while no write is open. The sweep sends every byte value and alternates the enable between bytes. It checks the latched value, the flag and the interrupt at fixed cycle offsets after each strobe change.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int PORT_W_DEF = 8;
    localparam int SYNC_DEF   = 2;

    typedef struct packed {
        logic full;      // buffer holds unacknowledged data
        logic intr;      // interrupt request
        logic ien;       // interrupt enable
        logic wstb_prv;  // synchronized write-active, previous cycle
        logic ackl_prv;  // synchronized ack-low, previous cycle
    } hsk_state_t;

    localparam hsk_state_t HSK_RST = '{default: 1'b0};

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
    import hsk_pkg::*;
#(
    parameter int PORT_W = PORT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wstb_s,   // synchronized: write in progress
    input  logic              ackl_s,   // synchronized: acknowledge low
    input  logic [PORT_W-1:0] wdata,
    input  logic              ien_we,
    input  logic              ien_val,
    output logic [PORT_W-1:0] dout,
    output logic              full,
    output logic              intr,
    output logic              ien
);

    hsk_state_t        st_d, st_q;
    logic [PORT_W-1:0] dout_d, dout_q;
    logic              wr_begin, wr_end, ack_rise;

    always_comb begin
        wr_begin = wstb_s & ~st_q.wstb_prv;
        wr_end   = ~wstb_s & st_q.wstb_prv;
        ack_rise = ~ackl_s & st_q.ackl_prv;

        st_d          = st_q;
        dout_d        = dout_q;
        st_d.wstb_prv = wstb_s;
        st_d.ackl_prv = ackl_s;

        if (ien_we) st_d.ien = ien_val;

        if (wr_end) dout_d = wdata;

        if (ackl_s)      st_d.full = 1'b0;
        else if (wr_end) st_d.full = 1'b1;

        if (wr_begin || !st_d.ien)          st_d.intr = 1'b0;
        else if (ack_rise && !st_d.full)    st_d.intr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= HSK_RST;
            dout_q <= '0;
        end else begin
            st_q   <= st_d;
            dout_q <= dout_d;
        end
    end

    assign dout = dout_q;
    assign full = st_q.full;
    assign intr = st_q.intr;
    assign ien  = st_q.ien;

    // R3: a low acknowledge empties the buffer on the next edge
    p_ack_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ackl_s |=> !st_q.full);

    // R2: a finished write with acknowledge idle fills the buffer
    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_end && !ackl_s) |=> st_q.full);

    // R2: data changes only at the end of a write
    p_data_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_end |=> $stable(dout_q));

    // R5: a starting write drops the interrupt
    p_begin_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_begin |=> !st_q.intr);

    // R6: interrupt never stands without the enable
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.intr |-> st_q.ien);

    // R4: interrupt rises only after acknowledge returned high
    p_irq_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.intr) |-> ($past(st_q.ackl_prv) && !$past(ackl_s)));

endmodule

// File: rtl/hsk_out_port.sv
module hsk_out_port
    import hsk_pkg::*;
#(
    parameter int PORT_W = PORT_W_DEF,
    parameter int SYNC_N = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [PORT_W-1:0] wdata,
    input  logic              ack_n,
    input  logic              ien_we,
    input  logic              ien_val,
    output logic [PORT_W-1:0] port_out,
    output logic              obf_n,
    output logic              irq,
    output logic [2:0]        status
);

    localparam int NSIG = 2;

    logic [NSIG-1:0] raw, synced;
    logic            full, intr, ien;

    assign raw = {~ack_n, ~(sel_n | wr_n)};

    hsk_sync #(.W(NSIG), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    hsk_ctrl #(.PORT_W(PORT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wstb_s  (synced[0]),
        .ackl_s  (synced[1]),
        .wdata   (wdata),
        .ien_we  (ien_we),
        .ien_val (ien_val),
        .dout    (port_out),
        .full    (full),
        .intr    (intr),
        .ien     (ien)
    );

    assign obf_n  = ~full;
    assign irq    = intr;
    assign status = {ien, intr, full};

    // R8: status bit 0 mirrors the inverted buffer-full pin
    p_status_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == !obf_n);

endmodule

// File: tb/hsk_out_port_bench.sv
`timescale 1ns/1ps
module hsk_out_port_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_n, wr_n, ack_n, ien_we, ien_val;
    logic [7:0] wdata;
    logic [7:0] port_out;
    logic       obf_n, irq;
    logic [2:0] status;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hsk_out_port u_hsk_out_port (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .wdata(wdata),
        .ack_n(ack_n), .ien_we(ien_we), .ien_val(ien_val),
        .port_out(port_out), .obf_n(obf_n), .irq(irq), .status(status)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ien(input logic v);
        ien_we = 1'b1; ien_val = v;
        step(1);
        ien_we = 1'b0;
        chk("R6 enable loaded", {31'b0, status[2]}, {31'b0, v});
    endtask

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; ack_n = 1'b1;
        ien_we = 1'b0; ien_val = 1'b0; wdata = 8'h00;
        step(3);
        rst_n = 1'b1;
        step(2);
        chk("R1 obf_n",   {31'b0, obf_n}, 32'd1);
        chk("R1 irq",     {31'b0, irq},   32'd0);
        chk("R1 status",  {29'b0, status}, 32'd0);
        chk("R1 port_out", {24'b0, port_out}, 32'd0);

        // R9 latency on write end
        wdata = 8'hA5; sel_n = 1'b0; wr_n = 1'b0;
        step(4);
        wr_n = 1'b1;
        step(2);
        chk("R9 not yet after two edges", {31'b0, obf_n}, 32'd1);
        step(1);
        chk("R9 visible after three edges", {31'b0, obf_n}, 32'd0);
        chk("R2 data latched", {24'b0, port_out}, 32'hA5);
        sel_n = 1'b1;
        step(3);
        ack_n = 1'b0; step(4);
        chk("R3 ack empties", {31'b0, obf_n}, 32'd1);
        ack_n = 1'b1; step(4);
        chk("R4 no irq when disabled", {31'b0, irq}, 32'd0);

        set_ien(1'b1);
        step(3);
        chk("R4 enable alone raises nothing", {31'b0, irq}, 32'd0);

        for (int b = 0; b < 256; b++) begin
            logic en;
            en = b[1];
            set_ien(en);
            if (!en) chk("R6 cleared enable drops irq", {31'b0, irq}, 32'd0);
            wdata = b[7:0]; sel_n = 1'b0; wr_n = 1'b0;
            step(4);
            chk("R5 write start clears irq", {31'b0, irq}, 32'd0);
            wr_n = 1'b1; step(4);
            sel_n = 1'b1;
            chk("R2 sweep data", {24'b0, port_out}, b);
            chk("R2 sweep obf_n", {31'b0, obf_n}, 32'd0);
            chk("R8 full bit", {31'b0, status[0]}, 32'd1);
            ack_n = 1'b0; step(4);
            chk("R3 sweep ack empties", {31'b0, obf_n}, 32'd1);
            ack_n = 1'b1; step(4);
            chk("R4 sweep irq", {31'b0, irq}, {31'b0, en});
            chk("R8 status word", {29'b0, status}, {29'b0, en, en, 1'b0});
        end

        // R7: strobe without select is ignored (state: enabled, irq high, data FF)
        wdata = 8'h3C; wr_n = 1'b0; step(4);
        wr_n = 1'b1; step(4);
        chk("R7 data unchanged", {24'b0, port_out}, 32'hFF);
        chk("R7 obf_n unchanged", {31'b0, obf_n}, 32'd1);
        chk("R7 irq unchanged", {31'b0, irq}, 32'd1);

        // R3: acknowledge held low across a whole write
        ack_n = 1'b0; step(4);
        wdata = 8'h5A; sel_n = 1'b0; wr_n = 1'b0; step(4);
        wr_n = 1'b1; step(4);
        sel_n = 1'b1;
        chk("R3 ack low dominates", {31'b0, obf_n}, 32'd1);
        chk("R3 data still latched", {24'b0, port_out}, 32'h5A);
        ack_n = 1'b1; step(4);
        chk("R4 irq after ack release", {31'b0, irq}, 32'd1);

        // R2: write closed by select instead of strobe
        wdata = 8'hC3; sel_n = 1'b0; wr_n = 1'b0; step(4);
        sel_n = 1'b1; step(4);
        wr_n = 1'b1;
        chk("R2 select-ended write data", {24'b0, port_out}, 32'hC3);
        chk("R2 select-ended write obf_n", {31'b0, obf_n}, 32'd0);
        chk("R5 irq dropped", {31'b0, irq}, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule